// File: doc/BRIEF.md
# Paging Control Register and Translation Flush Controller

This block keeps the paging-related control state of a 32-bit core: the machine control word (`cr0`), the page directory base (`cr3`), the extended feature word (`cr4`), and the mask for the 1 MiB address wrap. It takes one register write request per cycle and a level input for the address-wrap gate. It tells an external translation cache when it must drop entries, using two separate single-cycle pulses. One pulse drops every entry. The other drops only entries that are not marked global.

The block also derives hidden mode flags from the machine control word. These are the protected-mode flag, a flag that forces segment-base addition while in real mode, and three coprocessor flags. It exposes the current address mask to address generation. When the gate input changes level, the block rebuilds the mask, requests a full flush and pulses an exit request to the execution core.

Top module: `cr_flush_ctl`

## Requirements
- R1: A write to `cr0` (`wr_sel`=0) stores `wr_data` and raises `flush_all` only when bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) differs from the stored value.
- R2: A write to `cr4` (`wr_sel`=2) stores `wr_data` and raises `flush_all` only when bit 7 (global pages), bit 5 (extended addressing) or bit 4 (large pages) changes.
- R3: A write to `cr3` (`wr_sel`=1) always stores `wr_data`. It raises `flush_nonglobal` only when the stored `cr0` bit 31 is 1.
- R4: When `a20_gate` differs from `a20_mask` bit 20, the block sets `a20_mask` to 0xFFEFFFFF with bit 20 equal to `a20_gate`, raises `flush_all` and raises `exit_req`.
- R5: When `a20_gate` equals `a20_mask` bit 20 and no write is made, the mask does not change and no pulse is raised.
- R6: `flush_all`, `flush_nonglobal` and `exit_req` are registered. Each is high for the one cycle after the edge that samples its cause. A flushing write in the same cycle as a gate change gives one `flush_all` pulse. `flush_all` and `flush_nonglobal` are never high together, and a full flush takes the place of a non-global one.
- R7: `hf_pe` equals `cr0` bit 0, and `hf_addseg` is 1 whenever `cr0` bit 0 is 0.
- R8: `hf_mp`, `hf_em` and `hf_ts` equal `cr0` bits 1, 2 and 3.
- R9: After reset, `cr0` is 0x60000010, `cr3` and `cr4` are 0, `a20_mask` is 0xFFFFFFFF and all pulses are low.
- R10: A write with `wr_sel`=3 changes no register and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 2 | Target: 0 cr0, 1 cr3, 2 cr4, 3 none |
| wr_data | input | 32 | Write value |
| a20_gate | input | 1 | Address-wrap gate level |
| cr0_q | output | 32 | Machine control word |
| cr3_q | output | 32 | Page directory base |
| cr4_q | output | 32 | Extended feature word |
| a20_mask | output | 32 | Address mask for bit 20 |
| flush_all | output | 1 | Full translation flush pulse |
| flush_nonglobal | output | 1 | Non-global translation flush pulse |
| exit_req | output | 1 | Exit request pulse to the core |
| hf_pe | output | 1 | Protected-mode flag |
| hf_addseg | output | 1 | Forced segment-base-add flag |
| hf_mp | output | 1 | Coprocessor monitor flag |
| hf_em | output | 1 | Coprocessor emulation flag |
| hf_ts | output | 1 | Task-switched flag |

## Verification
The embedded properties check the following on every cycle:
- the two flush pulses never overlap;
- a mask change always comes with an exit request;
- the flush triggers for `cr0` and `cr4` fire;
- a non-global flush always traces back to a `cr3` write made while paging was on;
- quiet cycles and writes with selector 3 leave everything untouched.

Some behaviours can only be shown by the bench's scenarios, which compare against a cycle model:
- the exact reset values;
- the mask value after a series of gate toggles;
- the merge of a flushing write with a gate toggle into a single pulse;
- the hidden flags that follow after the protection-enable bit is toggled.

// File: rtl/cr_flush_ctl.sv
module cr_flush_ctl #(
  parameter int          XLEN     = 32,
  parameter int          WRAP_BIT = 20,
  parameter logic [31:0] CR0_INIT = 32'h6000_0010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            a20_gate,
  output logic [XLEN-1:0] cr0_q,
  output logic [XLEN-1:0] cr3_q,
  output logic [XLEN-1:0] cr4_q,
  output logic [XLEN-1:0] a20_mask,
  output logic            flush_all,
  output logic            flush_nonglobal,
  output logic            exit_req,
  output logic            hf_pe,
  output logic            hf_addseg,
  output logic            hf_mp,
  output logic            hf_em,
  output logic            hf_ts
);

  localparam logic [1:0] SEL_CR0 = 2'd0;
  localparam logic [1:0] SEL_CR3 = 2'd1;
  localparam logic [1:0] SEL_CR4 = 2'd2;
  localparam logic [XLEN-1:0] CR0_WATCH = XLEN'(32'h8001_0001);
  localparam logic [XLEN-1:0] CR4_WATCH = XLEN'(32'h0000_00B0);
  localparam int PG_BIT = 31;

  logic a20_on;

  wire wr_cr0 = wr_en && (wr_sel == SEL_CR0);
  wire wr_cr3 = wr_en && (wr_sel == SEL_CR3);
  wire wr_cr4 = wr_en && (wr_sel == SEL_CR4);

  wire cr0_hit = wr_cr0 && |((wr_data ^ cr0_q) & CR0_WATCH);
  wire cr4_hit = wr_cr4 && |((wr_data ^ cr4_q) & CR4_WATCH);
  wire a20_tgl = a20_gate != a20_on;

  wire full_nxt = cr0_hit | cr4_hit | a20_tgl;
  wire ng_nxt   = wr_cr3 & cr0_q[PG_BIT] & ~full_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_q           <= XLEN'(CR0_INIT);
      cr3_q           <= '0;
      cr4_q           <= '0;
      a20_on          <= 1'b1;
      flush_all       <= 1'b0;
      flush_nonglobal <= 1'b0;
      exit_req        <= 1'b0;
    end else begin
      if (wr_cr0) cr0_q <= wr_data;
      if (wr_cr3) cr3_q <= wr_data;
      if (wr_cr4) cr4_q <= wr_data;
      a20_on          <= a20_gate;
      flush_all       <= full_nxt;
      flush_nonglobal <= ng_nxt;
      exit_req        <= a20_tgl;
    end
  end

  assign a20_mask  = ~(XLEN'(!a20_on) << WRAP_BIT);
  assign hf_pe     = cr0_q[0];
  assign hf_addseg = ~cr0_q[0];
  assign hf_mp     = cr0_q[1];
  assign hf_em     = cr0_q[2];
  assign hf_ts     = cr0_q[3];

  p_cr0_flush_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && ((wr_data ^ cr0_q) & 32'h8001_0001) != 0) |=> flush_all);

  p_cr4_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && ((wr_data ^ cr4_q) & 32'h0000_00B0) != 0) |=> flush_all);

  p_ng_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_nonglobal |-> $past(wr_en && wr_sel == 2'd1 && cr0_q[31]));

  p_cr3_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> cr3_q == $past(wr_data));

  p_mask_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(a20_mask) |-> (exit_req && flush_all));

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && a20_gate == a20_mask[20]) |=> (!flush_all && !flush_nonglobal && !exit_req));

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_all && flush_nonglobal));

  p_nosel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3 && a20_gate == a20_mask[20]) |=>
      ($stable(cr0_q) && $stable(cr3_q) && $stable(cr4_q) && !flush_all && !flush_nonglobal));

endmodule

// File: tb/cr_flush_ctl_tb.sv
module cr_flush_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic a20_gate = 1'b1;
  logic [31:0] cr0_q, cr3_q, cr4_q, a20_mask;
  logic flush_all, flush_nonglobal, exit_req;
  logic hf_pe, hf_addseg, hf_mp, hf_em, hf_ts;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_cr0 = 32'h6000_0010, m_cr3 = '0, m_cr4 = '0, m_mask = 32'hFFFF_FFFF;
  logic m_fa = 1'b0, m_ng = 1'b0, m_ex = 1'b0;

  always #10 clk = ~clk;

  cr_flush_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .a20_gate(a20_gate), .cr0_q(cr0_q), .cr3_q(cr3_q), .cr4_q(cr4_q),
    .a20_mask(a20_mask), .flush_all(flush_all), .flush_nonglobal(flush_nonglobal),
    .exit_req(exit_req), .hf_pe(hf_pe), .hf_addseg(hf_addseg), .hf_mp(hf_mp),
    .hf_em(hf_em), .hf_ts(hf_ts)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 cr0", cr0_q, m_cr0);
    chk("R3 cr3", cr3_q, m_cr3);
    chk("R2 cr4", cr4_q, m_cr4);
    chk("R4 a20_mask", a20_mask, m_mask);
    chk("R1/R2/R4 flush_all", 32'(flush_all), 32'(m_fa));
    chk("R3 flush_nonglobal", 32'(flush_nonglobal), 32'(m_ng));
    chk("R4 exit_req", 32'(exit_req), 32'(m_ex));
    chk("R7 flags", {hf_pe, hf_addseg}, {m_cr0[0], ~m_cr0[0]});
    chk("R8 fpu flags", {hf_mp, hf_em, hf_ts}, {m_cr0[1], m_cr0[2], m_cr0[3]});
  endtask

  // Reference model: state after the next rising edge, given the inputs now applied.
  task automatic model_step();
    bit fa = 0, ng = 0, ex = 0;
    if (a20_gate != m_mask[20]) begin
      fa = 1; ex = 1;
      m_mask = a20_gate ? 32'hFFFF_FFFF : 32'hFFEF_FFFF;
    end
    if (wr_en) begin
      if (wr_sel == 2'd0) begin
        if (wr_data[31] != m_cr0[31] || wr_data[16] != m_cr0[16] || wr_data[0] != m_cr0[0]) fa = 1;
        m_cr0 = wr_data;
      end else if (wr_sel == 2'd1) begin
        if (m_cr0[31]) ng = 1;
        m_cr3 = wr_data;
      end else if (wr_sel == 2'd2) begin
        if (wr_data[7] != m_cr4[7] || wr_data[5] != m_cr4[5] || wr_data[4] != m_cr4[4]) fa = 1;
        m_cr4 = wr_data;
      end
    end
    if (fa) ng = 0;
    m_fa = fa; m_ng = ng; m_ex = ex;
  endtask

  task automatic cyc(input logic en, input logic [1:0] sel, input logic [31:0] d, input logic g);
    wr_en = en; wr_sel = sel; wr_data = d; a20_gate = g;
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all();
    chk("R9 reset cr0", cr0_q, 32'h6000_0010);
    chk("R9 reset mask", a20_mask, 32'hFFFF_FFFF);
    chk("R9 reset pulses", {29'd0, flush_all, flush_nonglobal, exit_req}, 32'd0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 1);
    chk("R5 idle no pulse", {29'd0, flush_all, flush_nonglobal, exit_req}, 32'd0);
    // R3: paging off, cr3 write stores without flush
    cyc(1, 1, 32'h0001_2000, 1);
    chk("R3 no ng flush with paging off", 32'(flush_nonglobal), 32'd0);
    // R1: only non-watched bits change
    cyc(1, 0, 32'h6000_001E, 1);
    chk("R1 no flush on unwatched bits", 32'(flush_all), 32'd0);
    chk("R8 mp/em/ts", {hf_mp, hf_em, hf_ts}, 32'b111);
    // R1: enable paging and protection
    cyc(1, 0, 32'h8000_0011, 1);
    chk("R1 flush on PG/PE change", 32'(flush_all), 32'd1);
    chk("R7 pe set", {hf_pe, hf_addseg}, 32'b10);
    cyc(0, 0, 0, 1);
    chk("R6 pulse one cycle", 32'(flush_all), 32'd0);
    // R3: paging on
    cyc(1, 1, 32'h0004_5000, 1);
    chk("R3 ng flush with paging on", {flush_all, flush_nonglobal}, 32'b01);
    // R2
    cyc(1, 2, 32'h0000_0010, 1);
    chk("R2 flush on PSE change", 32'(flush_all), 32'd1);
    cyc(1, 2, 32'h0000_0213, 1);
    chk("R2 no flush on other bits", 32'(flush_all), 32'd0);
    // R4: gate low
    cyc(0, 0, 0, 0);
    chk("R4 mask low", a20_mask, 32'hFFEF_FFFF);
    chk("R4 exit", {flush_all, exit_req}, 32'b11);
    // R5: gate held at same value
    cyc(0, 0, 0, 0);
    chk("R5 same gate no pulse", {29'd0, flush_all, flush_nonglobal, exit_req}, 32'd0);
    // R6: cr3 write with toggle -> full only
    cyc(1, 1, 32'h0007_7000, 1);
    chk("R6 full replaces ng", {flush_all, flush_nonglobal}, 32'b10);
    // R6: cr0 flush coincides with toggle
    cyc(1, 0, 32'h0000_0010, 0);
    chk("R6 merged single pulse", {flush_all, exit_req}, 32'b11);
    cyc(0, 0, 0, 0);
    chk("R6 merged pulse ends", 32'(flush_all), 32'd0);
    chk("R7 addseg forced", {hf_pe, hf_addseg}, 32'b01);
    // R10
    cyc(1, 3, 32'hFFFF_FFFF, 0);
    chk("R10 sel3 cr0 kept", cr0_q, 32'h0000_0010);
    chk("R10 sel3 no pulse", {29'd0, flush_all, flush_nonglobal, exit_req}, 32'd0);
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom();
      if ($urandom_range(0, 1) == 1) d = (d & 32'h7FFE_FF4E) | (m_cr0 & 32'h8001_00B1);
      cyc($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), d,
          ($urandom_range(0, 7) == 0) ? ~a20_gate : a20_gate);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule